// File: doc/BRIEF.md
# Cartridge ROM Window with Header Autostart Scan

This block places an 8 KiB cartridge ROM into a 16-bit CPU address space. When either of the two active-low cartridge control lines is low, a CPU read that lands in the 8 KiB window based at $8000 is served from the ROM. The ROM sees only the offset inside the window, so CPU address $8000 reaches ROM offset $0000. Any other read returns the system memory data input unchanged. The read data is split into separate input and output buses, and the block uses no internal tri-state bus.

After a synchronous reset a small sequencer reads the first nine header bytes, one per clock. Bytes 0-1 form the cold-start entry pointer and bytes 2-3 form the NMI entry pointer, each with the low byte first. Bytes 4-8 are compared against a five-byte autostart signature. A single autostart flag reports the result, and it is qualified by the control lines. The ROM image is a model: its first sixteen bytes come from a parameter vector, and a computed pattern fills the rest.

All pins are plain level signals. The CPU bus has no handshake and never applies back-pressure, because a read strobe is answered exactly one clock later.

Top module: `cart_window`

## Requirements
- R1: `cart_sel` is high in the cycle after a rising edge at which `cpu_rd` was high and `cpu_addr` was in $8000-$9FFF with the window enabled. It is low after any edge at which one of these conditions was false.
- R2: The window is enabled when `game_n` is low, when `exrom_n` is low, or when both are low. With both lines high, no address selects the ROM.
- R3: The ROM offset equals `cpu_addr[12:0]`. In the cycle after a selected read, `rd_data` carries the ROM byte at that offset, so $8000 reads offset $0000 and $9FFF reads offset $1FFF.
- R4: While `cart_sel` is low, `rd_data` equals `sys_data` in the same cycle, with no register in that path.
- R5: ROM offsets 0-15 hold byte i of `HDR_INIT` (bits 8i+7..8i). Every offset k of 16 or more holds k[7:0] XOR k[12:8] XOR $5A.
- R6: The sequencer starts after reset release and reads offsets 0..8, one per clock. If offsets 4..8 hold $C3, $C2, $CD, $38, $30 in that order, `autostart` is high from the tenth rising edge after reset release. It is low after the ninth edge.
- R7: At the first signature byte that does not match, the scan stops. `autostart` then stays low until the next reset, whatever the CPU reads.
- R8: `vec_reset` = {offset 1, offset 0} and `vec_nmi` = {offset 3, offset 2}. Both are complete by the tenth edge after reset release, even when the signature fails, and stay constant afterwards.
- R9: `rst_n` is a synchronous active-low reset. It clears `cart_sel`, `autostart`, `vec_reset` and `vec_nmi`.
- R10: `autostart` is low whenever `game_n` and `exrom_n` are both high, even after a matching scan. It follows the lines in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe, active high |
| game_n | input | 1 | Cartridge control line, active low |
| exrom_n | input | 1 | Cartridge control line, active low |
| sys_data | input | 8 | Data from system memory |
| rd_data | output | 8 | Data returned to the CPU |
| cart_sel | output | 1 | High in the cycle that carries ROM data |
| autostart | output | 1 | Signature matched and window enabled |
| vec_reset | output | 16 | Cold-start entry pointer from the header |
| vec_nmi | output | 16 | NMI entry pointer from the header |

## Verification
The block has three result timings:
- **ROM reads:** data and `cart_sel` arrive one cycle after the address and strobe. The bench drives each read on a falling edge and samples on the next falling edge, which lies after exactly one capturing rising edge.
- **Pass-through:** this path has no latency. The bench changes `sys_data` and samples `rd_data` one nanosecond later within the same cycle.
- **Scan:** the result is due on the tenth rising edge after reset release. The bench samples after the ninth edge to confirm the flag is still low, and again after the tenth edge, on one instance with a good header and one with a corrupted signature.

// File: rtl/cart_pkg.sv
package cart_pkg;
  // Autostart signature, byte 0 in the least significant position.
  localparam int SIG_LEN  = 5;
  localparam int SIG_OFS  = 4;
  localparam int HDR_SCAN = SIG_OFS + SIG_LEN;
  localparam logic [8*SIG_LEN-1:0] SIG_BYTES = 40'h30_38_CD_C2_C3;

  typedef enum logic [1:0] {SC_RUN, SC_DRAIN, SC_DONE} scan_st_e;

  function automatic logic [7:0] sig_byte(input int i);
    return SIG_BYTES[i*8 +: 8];
  endfunction

  // Deterministic filler for the ROM body beyond the header.
  function automatic logic [7:0] body_fill(input logic [31:0] off);
    return off[7:0] ^ off[15:8] ^ 8'h5A;
  endfunction
endpackage

// File: rtl/cart_rom.sv
module cart_rom #(
  parameter int ADDR_W = 13,
  parameter int HDR_N  = 16,
  parameter logic [HDR_N*8-1:0] HDR_INIT = '0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        q
);
  localparam int HI_W = $clog2(HDR_N);

  function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a);
    if (32'(a) < 32'(HDR_N)) return HDR_INIT[int'(a[HI_W-1:0])*8 +: 8];
    return cart_pkg::body_fill(32'(a));
  endfunction

  // Registered read so the image maps onto synchronous memory.
  always_ff @(posedge clk) q <= byte_at(addr);
endmodule

// File: rtl/cart_decode.sv
module cart_decode #(
  parameter int CPU_AW = 16,
  parameter int ADDR_W = 13,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              game_n,
  input  logic              exrom_n,
  output logic              win_en,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic in_range;
  assign win_en   = ~(game_n & exrom_n);
  assign in_range = (cpu_addr[CPU_AW-1:ADDR_W] == WIN_BASE[CPU_AW-1:ADDR_W]);
  assign hit      = cpu_rd & win_en & in_range;
  assign offset   = cpu_addr[ADDR_W-1:0];
endmodule

// File: rtl/cart_scan.sv
module cart_scan #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rom_q,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              sig_ok,
  output logic              done,
  output logic [15:0]       vec_reset,
  output logic [15:0]       vec_nmi
);
  import cart_pkg::*;
  localparam int IDX_W = $clog2(HDR_SCAN + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(HDR_SCAN - 1);

  scan_st_e         st;
  logic [IDX_W-1:0] idx, pend_idx;
  logic             pend_v;

  assign scan_addr = ADDR_W'(idx);
  assign done      = (st == SC_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SC_RUN; idx <= '0; pend_idx <= '0; pend_v <= 1'b0;
      sig_ok <= 1'b0; vec_reset <= '0; vec_nmi <= '0;
    end else begin
      pend_v <= 1'b0;
      if (st == SC_RUN) begin
        pend_v   <= 1'b1;
        pend_idx <= idx;
        if (idx == LAST) st <= SC_DRAIN;
        else             idx <= idx + 1'b1;
      end
      if (pend_v) begin
        if (pend_idx == IDX_W'(0)) vec_reset[7:0]  <= rom_q;
        if (pend_idx == IDX_W'(1)) vec_reset[15:8] <= rom_q;
        if (pend_idx == IDX_W'(2)) vec_nmi[7:0]    <= rom_q;
        if (pend_idx == IDX_W'(3)) vec_nmi[15:8]   <= rom_q;
        if (int'(pend_idx) >= SIG_OFS) begin
          if (rom_q != sig_byte(int'(pend_idx) - SIG_OFS)) begin
            st     <= SC_DONE;
            pend_v <= 1'b0;
          end else if (pend_idx == LAST) begin
            sig_ok <= 1'b1;
            st     <= SC_DONE;
          end
        end
      end
    end
  end

  p_ok_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sig_ok |-> done);
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < HDR_SCAN);
  p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(sig_ok));
  p_vec_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(vec_reset) && $stable(vec_nmi));
endmodule

// File: rtl/cart_window.sv
module cart_window #(
  parameter int CPU_AW = 16,
  parameter int ADDR_W = 13,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h8000,
  parameter int HDR_N = 16,
  parameter logic [HDR_N*8-1:0] HDR_INIT = 128'h0000_0000_0000_0030_38CD_C2C3_80A0_8009
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              game_n,
  input  logic              exrom_n,
  input  logic [7:0]        sys_data,
  output logic [7:0]        rd_data,
  output logic              cart_sel,
  output logic              autostart,
  output logic [15:0]       vec_reset,
  output logic [15:0]       vec_nmi
);
  localparam int N_PORT = 2;   // port 0: CPU, port 1: header scan

  logic              win_en, hit, sel_q, sig_ok, scan_done;
  logic [ADDR_W-1:0] cpu_off, scan_addr;
  logic [ADDR_W-1:0] port_addr [N_PORT];
  logic [7:0]        port_q    [N_PORT];

  cart_decode #(.CPU_AW(CPU_AW), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .game_n(game_n), .exrom_n(exrom_n),
    .win_en(win_en), .hit(hit), .offset(cpu_off));

  assign port_addr[0] = cpu_off;
  assign port_addr[1] = scan_addr;

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    cart_rom #(.ADDR_W(ADDR_W), .HDR_N(HDR_N), .HDR_INIT(HDR_INIT)) u_rom (
      .clk(clk), .addr(port_addr[p]), .q(port_q[p]));
  end

  cart_scan #(.ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .rom_q(port_q[1]), .scan_addr(scan_addr),
    .sig_ok(sig_ok), .done(scan_done), .vec_reset(vec_reset), .vec_nmi(vec_nmi));

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= hit;
  end

  assign cart_sel  = sel_q;
  assign rd_data   = sel_q ? port_q[0] : sys_data;
  assign autostart = sig_ok & win_en;

  p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cart_sel |-> $past(cpu_rd) &&
      ($past(cpu_addr[CPU_AW-1:ADDR_W]) == WIN_BASE[CPU_AW-1:ADDR_W]));
  p_sel_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cart_sel |-> !($past(game_n) && $past(exrom_n)));
  p_auto_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (game_n && exrom_n) |-> !autostart);
  p_auto_after_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    autostart |-> scan_done);
endmodule

// File: tb/cart_window_bench.sv
`timescale 1ns/1ps
module cart_window_bench;
  localparam logic [127:0] HDR_GOOD = 128'h0000_0000_0000_0030_38CD_C2C3_80A0_8009;
  localparam logic [127:0] HDR_BAD  = 128'h0000_0000_0000_0030_384D_C2C3_8123_8010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic cpu_rd = 1'b0, game_n = 1'b0, exrom_n = 1'b1;
  logic [7:0] sys_data = 8'h6B;
  logic [7:0] rd_g, rd_b;
  logic sel_g, sel_b, auto_g, auto_b;
  logic [15:0] vr_g, vn_g, vr_b, vn_b;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cart_window #(.HDR_INIT(HDR_GOOD)) u_cart_window (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .game_n(game_n), .exrom_n(exrom_n), .sys_data(sys_data), .rd_data(rd_g),
    .cart_sel(sel_g), .autostart(auto_g), .vec_reset(vr_g), .vec_nmi(vn_g));
  cart_window #(.HDR_INIT(HDR_BAD)) u_cart_window_bad (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .game_n(game_n), .exrom_n(exrom_n), .sys_data(sys_data), .rd_data(rd_b),
    .cart_sel(sel_b), .autostart(auto_b), .vec_reset(vr_b), .vec_nmi(vn_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [127:0] hdr, input int off);
    if (off < 16) return hdr[off*8 +: 8];
    return 8'(off & 255) ^ 8'((off >> 8) & 255) ^ 8'h5A;
  endfunction

  task automatic do_read(input logic [15:0] a, input logic rd);
    @(negedge clk); cpu_addr = a; cpu_rd = rd;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 sel in reset", sel_g, 0);
    chk("R9 autostart in reset", auto_g, 0);
    chk("R9 vec_reset in reset", vr_g, 0);
    chk("R9 vec_nmi in reset", vn_g, 0);
    chk("R4 passthru in reset", rd_g, sys_data);
  endtask

  task automatic t_scan;
    rst_n = 1'b1;                       // driven at a falling edge
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R6 not yet after edge 9", auto_g, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 match after edge 10", auto_g, 1);
    chk("R8 vec_reset good", vr_g, 16'h8009);
    chk("R8 vec_nmi good", vn_g, 16'h80A0);
    chk("R7 mismatch no autostart", auto_b, 0);
    chk("R8 vec_reset on mismatch", vr_b, 16'h8010);
    chk("R8 vec_nmi on mismatch", vn_b, 16'h8123);
  endtask

  task automatic t_header_reads;
    for (int i = 0; i < 16; i++) begin
      do_read(16'h8000 + 16'(i), 1'b1);
      chk("R3 header sel", sel_g, 1);
      chk("R5 header byte", rd_g, exp_byte(HDR_GOOD, i));
      chk("R5 bad header byte", rd_b, exp_byte(HDR_BAD, i));
    end
  endtask

  task automatic t_body_reads;
    int offs [4] = '{16, 300, 4660, 8191};
    foreach (offs[k]) begin
      do_read(16'h8000 + 16'(offs[k]), 1'b1);
      chk("R3 body sel", sel_g, 1);
      chk("R5 body byte", rd_g, exp_byte(HDR_GOOD, offs[k]));
    end
  endtask

  task automatic t_outside;
    do_read(16'h7FFF, 1'b1);
    chk("R1 below window sel", sel_g, 0);
    chk("R4 below window data", rd_g, sys_data);
    do_read(16'hA000, 1'b1);
    chk("R1 above window sel", sel_g, 0);
    chk("R4 above window data", rd_g, sys_data);
    do_read(16'h8004, 1'b0);
    chk("R1 no strobe sel", sel_g, 0);
    chk("R4 no strobe data", rd_g, sys_data);
    sys_data = 8'hE7; #1;
    chk("R4 same-cycle passthru", rd_g, 8'hE7);
  endtask

  task automatic t_lines;
    game_n = 1'b1; exrom_n = 1'b0;
    do_read(16'h8005, 1'b1);
    chk("R2 exrom only sel", sel_g, 1);
    chk("R2 exrom only data", rd_g, 8'hC2);
    chk("R10 exrom only autostart", auto_g, 1);
    game_n = 1'b1; exrom_n = 1'b1;
    do_read(16'h8005, 1'b1);
    chk("R2 both high sel", sel_g, 0);
    chk("R2 both high data", rd_g, sys_data);
    chk("R10 both high autostart", auto_g, 0);
    game_n = 1'b0; exrom_n = 1'b0;
    do_read(16'h8006, 1'b1);
    chk("R2 both low sel", sel_g, 1);
    chk("R2 both low data", rd_g, 8'hCD);
    chk("R10 both low autostart", auto_g, 1);
    chk("R7 bad stays low", auto_b, 0);
  endtask

  task automatic t_vec_hold;
    @(negedge clk); cpu_rd = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R8 vec_reset held", vr_g, 16'h8009);
    chk("R8 vec_nmi held", vn_g, 16'h80A0);
    chk("R7 bad still low", auto_b, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_scan();
    t_header_reads();
    t_body_reads();
    t_outside();
    t_lines();
    t_vec_hold();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule